// File: doc/BRIEF.md
# Strobed Byte Loader for a Board-Addressed Register Bank

This block accepts writes from a host over a write-only, byte-wide bus with eight data lines and two write strobes. One strobe latches a byte into a staging (holding) register. The other latches a byte into an address register that carries a load flag, a board number and a register number. A copy from the holding register into a target register happens only when two conditions are met. The load flag must go from one to zero between two consecutive address writes, and the board number of the falling write must equal the board's strapped identity. This lets several boards share one daisy-chained bus.

A complete load is three writes: the data byte to the holding register, the address with the flag set, then the same address with the flag clear. The target bank holds two 8-bit control registers and a 16-bit sample word built from two byte registers.

Bit 0 of the second control register drives a device clock, so the host produces one clock pulse with two loads. The bus lines and strobes are asynchronous to the system clock. They pass through two-stage synchronizers before the block looks for edges.

The sequencer has three states:
- `ST_LOW`: the flag was last written as zero.
- `ST_HIGH`: the flag was last written as one.
- `ST_XFER`: a one-cycle copy is taking place.

The transitions are:
- `ST_LOW`→`ST_HIGH` on an address write with the flag set.
- `ST_HIGH`→`ST_XFER` on an address write with the flag clear and a matching board.
- `ST_HIGH`→`ST_LOW` on an address write with the flag clear and a foreign board.
- `ST_HIGH`→`ST_HIGH` on an address write with the flag still set.
- `ST_XFER`→`ST_HIGH` on an address write with the flag set arriving in that cycle.
- `ST_XFER`→`ST_LOW` otherwise.

Top module: `regload_top`

## Requirements
- R1: After reset, ctrl_a, ctrl_b and din_word are zero, and dev_clk is low.
- R2: A rising edge on wr_hold_stb stores bus_data in the holding register. The most recently stored byte is the one that a later copy writes.
- R3: A rising edge on wr_addr_stb stores bus_data as an address byte with this layout: bit 7 is the load flag, bits 5..3 are the board number and bits 2..0 are the register number. Bit 6 is ignored.
- R4: A copy happens only when an address write with the flag clear directly follows an address write with the flag set. Two consecutive address writes with the flag clear copy nothing.
- R5: A copy happens only if the board number of the falling write equals board_id. Otherwise no register changes.
- R6: Register numbers map as follows: 0 loads ctrl_a, 1 loads ctrl_b, 2 loads din_word[7:0] and 3 loads din_word[15:8]. Numbers 4 to 7 change nothing.
- R7: dev_clk equals bit 0 of ctrl_b.
- R8: serial_out equals dev_out[ctrl_a[2:0]].
- R9: An address write that keeps the flag set while changing the board or register number copies nothing. The following write with the flag clear copies into the register named in that falling write.
- R10: A target register changes only in the clock cycle after the sequencer is in `ST_XFER`, and it changes at most once per load sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | input | 8 | Asynchronous host data lines |
| wr_addr_stb | input | 1 | Address write strobe, active on its rising edge |
| wr_hold_stb | input | 1 | Holding write strobe, active on its rising edge |
| board_id | input | 3 | Strapped board number |
| dev_out | input | 8 | Output bits of the attached device, for readback |
| ctrl_a | output | 8 | Control register 0; bits 2..0 select the readback bit |
| ctrl_b | output | 8 | Control register 1; bit 0 is the device clock |
| din_word | output | 16 | Sample word driven to the device |
| dev_clk | output | 1 | Software-generated device clock |
| serial_out | output | 1 | Selected device output bit |

## Verification
The assertions check the following on every cycle:
- A copy only ever follows a falling flag on a write that names this board.
- The copy state never lasts longer than one cycle.
- The register outputs stay still in every other cycle.
- A copy to register numbers 4 to 7 leaves the bank untouched.
- The readback line always shows the bit selected by ctrl_a.

The bench's scenarios are needed for the rest:
- which byte lands in which register;
- that an ignored bit 6 leaves decoding intact;
- that two flag-clear writes in a row do nothing;
- that a field change while the flag stays set copies nothing and leaves the next falling write in charge;
- that two loads of ctrl_b give a clean dev_clk pulse.

// File: rtl/regload_pkg.sv
package regload_pkg;
    localparam int BUS_W     = 8;
    localparam int BOARD_W   = 3;
    localparam int REGSEL_W  = 3;
    localparam int FLAG_BIT  = 7;
    localparam int BOARD_LSB = 3;

    localparam logic [REGSEL_W-1:0] IDX_CTRL_A = 3'd0;
    localparam logic [REGSEL_W-1:0] IDX_CTRL_B = 3'd1;
    localparam logic [REGSEL_W-1:0] IDX_DIN_LO = 3'd2;
    localparam logic [REGSEL_W-1:0] IDX_DIN_HI = 3'd3;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HIGH = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;
endpackage

// File: rtl/regload_sync.sv
module regload_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/regload_ctl.sv
module regload_ctl
    import regload_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_W-1:0]    data_s,
    input  logic                addr_stb_s,
    input  logic                hold_stb_s,
    input  logic [BOARD_W-1:0]  board_id,
    output logic                xfer_go,
    output logic [REGSEL_W-1:0] xfer_idx,
    output logic [BUS_W-1:0]    hold_q,
    output logic [BUS_W-1:0]    addr_q
);
    seq_state_e state_q, state_d;
    logic addr_prev, hold_prev;
    logic addr_rise, hold_rise;
    logic new_flag, board_hit;

    assign addr_rise = addr_stb_s & ~addr_prev;
    assign hold_rise = hold_stb_s & ~hold_prev;
    assign new_flag  = data_s[FLAG_BIT];
    assign board_hit = (data_s[BOARD_LSB +: BOARD_W] == board_id);

    // staging registers: strobe history, holding byte and address byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_prev <= 1'b0;
            hold_prev <= 1'b0;
            hold_q    <= '0;
            addr_q    <= '0;
        end else begin
            addr_prev <= addr_stb_s;
            hold_prev <= hold_stb_s;
            if (hold_rise) hold_q <= data_s;
            if (addr_rise) addr_q <= data_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (addr_rise && new_flag) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (addr_rise && !new_flag) state_d = board_hit ? ST_XFER : ST_LOW;
            end
            ST_XFER: begin
                state_d = (addr_rise && new_flag) ? ST_HIGH : ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    // outputs
    always_comb begin
        xfer_go  = (state_q == ST_XFER);
        xfer_idx = addr_q[REGSEL_W-1:0];
    end
endmodule

// File: rtl/regload_bank.sv
module regload_bank
    import regload_pkg::*;
#(
    parameter int CTRL_W = 8,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_go,
    input  logic [REGSEL_W-1:0] xfer_idx,
    input  logic [BUS_W-1:0]    hold_q,
    output logic [CTRL_W-1:0]   ctrl_a,
    output logic [CTRL_W-1:0]   ctrl_b,
    output logic [WORD_W-1:0]   din_word
);
    localparam int HALF_W = WORD_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a   <= '0;
            ctrl_b   <= '0;
            din_word <= '0;
        end else if (xfer_go) begin
            case (xfer_idx)
                IDX_CTRL_A: ctrl_a <= CTRL_W'(hold_q);
                IDX_CTRL_B: ctrl_b <= CTRL_W'(hold_q);
                IDX_DIN_LO: din_word[HALF_W-1:0]      <= HALF_W'(hold_q);
                IDX_DIN_HI: din_word[WORD_W-1:HALF_W] <= HALF_W'(hold_q);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/regload_top.sv
module regload_top
    import regload_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W      = 8,
    parameter int WORD_W      = 16,
    parameter int PROBE_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   bus_data,
    input  logic               wr_addr_stb,
    input  logic               wr_hold_stb,
    input  logic [BOARD_W-1:0] board_id,
    input  logic [PROBE_W-1:0] dev_out,
    output logic [CTRL_W-1:0]  ctrl_a,
    output logic [CTRL_W-1:0]  ctrl_b,
    output logic [WORD_W-1:0]  din_word,
    output logic               dev_clk,
    output logic               serial_out
);
    localparam int SYNC_W = BUS_W + 2;
    localparam int PSEL_W = $clog2(PROBE_W);

    logic [SYNC_W-1:0]   sync_vec;
    logic [BUS_W-1:0]    data_s;
    logic                addr_stb_s, hold_stb_s;
    logic                xfer_go;
    logic [REGSEL_W-1:0] xfer_idx;
    logic [BUS_W-1:0]    hold_q, addr_q;

    regload_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({wr_addr_stb, wr_hold_stb, bus_data}),
        .sync_out (sync_vec)
    );

    assign {addr_stb_s, hold_stb_s, data_s} = sync_vec;

    regload_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_s     (data_s),
        .addr_stb_s (addr_stb_s),
        .hold_stb_s (hold_stb_s),
        .board_id   (board_id),
        .xfer_go    (xfer_go),
        .xfer_idx   (xfer_idx),
        .hold_q     (hold_q),
        .addr_q     (addr_q)
    );

    regload_bank #(.CTRL_W(CTRL_W), .WORD_W(WORD_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_go  (xfer_go),
        .xfer_idx (xfer_idx),
        .hold_q   (hold_q),
        .ctrl_a   (ctrl_a),
        .ctrl_b   (ctrl_b),
        .din_word (din_word)
    );

    assign dev_clk    = ctrl_b[0];
    assign serial_out = dev_out[ctrl_a[PSEL_W-1:0]];
endmodule

// File: rtl/regload_chk.sv
module regload_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_go,
    input logic [7:0]  addr_q,
    input logic [2:0]  board_id,
    input logic [7:0]  ctrl_a,
    input logic [7:0]  ctrl_b,
    input logic [15:0] din_word,
    input logic [7:0]  dev_out,
    input logic        serial_out
);
    AST_XFER_BOARD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> (addr_q[5:3] == board_id) && !addr_q[7]); // R5

    AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> !xfer_go); // R4

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_go |=> ($stable(ctrl_a) && $stable(ctrl_b) && $stable(din_word))); // R10

    AST_UPPER_IDX_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && addr_q[2]) |=> ($stable(ctrl_a) && $stable(ctrl_b) && $stable(din_word))); // R6

    AST_READBACK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        serial_out == dev_out[ctrl_a[2:0]]); // R8
endmodule

bind regload_top regload_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_go    (xfer_go),
    .addr_q     (addr_q),
    .board_id   (board_id),
    .ctrl_a     (ctrl_a),
    .ctrl_b     (ctrl_b),
    .din_word   (din_word),
    .dev_out    (dev_out),
    .serial_out (serial_out)
);

// File: tb/tb_regload_top.sv
`timescale 1ns/1ps
module tb_regload_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        wr_addr_stb = 1'b0;
    logic        wr_hold_stb = 1'b0;
    logic [2:0]  board_id = 3'd5;
    logic [7:0]  dev_out = '0;
    logic [7:0]  ctrl_a, ctrl_b;
    logic [15:0] din_word;
    logic        dev_clk, serial_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  exp_a = '0, exp_b = '0;
    logic [15:0] exp_w = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        chk_ev;

    always #2 clk = ~clk;

    regload_top dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
        .wr_addr_stb(wr_addr_stb), .wr_hold_stb(wr_hold_stb),
        .board_id(board_id), .dev_out(dev_out),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .din_word(din_word),
        .dev_clk(dev_clk), .serial_out(serial_out)
    );

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input bit to_addr, input logic [7:0] val);
        bus_data = val;
        wait_cyc(3);
        if (to_addr) wr_addr_stb = 1'b1; else wr_hold_stb = 1'b1;
        wait_cyc(4);
        wr_addr_stb = 1'b0;
        wr_hold_stb = 1'b0;
        wait_cyc(6);
    endtask

    // full three-write load; updates the expected model per R3..R6
    task automatic load(input logic [2:0] brd, input logic [2:0] idx, input logic [7:0] val);
        bus_write(1'b0, val);
        bus_write(1'b1, {1'b1, 1'b0, brd, idx});
        bus_write(1'b1, {1'b0, 1'b0, brd, idx});
        if (brd == board_id) begin
            case (idx)
                3'd0: exp_a = val;
                3'd1: exp_b = val;
                3'd2: exp_w[7:0] = val;
                3'd3: exp_w[15:8] = val;
                default: ;
            endcase
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_now(input string tag);
        exp_q.push_back({exp_w, exp_b, exp_a});
        tag_q.push_back(tag);
        ->chk_ev;
        wait_cyc(2);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                logic [31:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {din_word, ctrl_b, ctrl_a};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        wait_cyc(200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        expect_now("R1 reset state");
        check_bit("R1 dev_clk reset", dev_clk, 1'b0);

        load(3'd5, 3'd2, 8'h34);
        expect_now("R6 data low byte");
        load(3'd5, 3'd3, 8'hA1);
        expect_now("R6 data high byte");
        load(3'd5, 3'd0, 8'h03);
        expect_now("R2 ctrl_a load");

        // R2: second holding write overrides the first
        bus_write(1'b0, 8'h11);
        bus_write(1'b0, 8'h06);
        bus_write(1'b1, 8'hA8);
        bus_write(1'b1, 8'h28);
        exp_a = 8'h06;
        expect_now("R2 latest holding byte");

        // R5: foreign board
        load(3'd2, 3'd0, 8'hFF);
        expect_now("R5 foreign board ignored");

        // R6: upper register numbers change nothing
        load(3'd5, 3'd4, 8'h5A);
        load(3'd5, 3'd7, 8'hC3);
        expect_now("R6 index 4..7 ignored");

        // R3: bit 6 ignored
        bus_write(1'b0, 8'h9C);
        bus_write(1'b1, 8'hEA);
        bus_write(1'b1, 8'h6A);
        exp_w[7:0] = 8'h9C;
        expect_now("R3 bit6 ignored");

        // R4: flag-clear write repeated copies nothing
        bus_write(1'b0, 8'h77);
        bus_write(1'b1, 8'h2B);
        expect_now("R4 low-low no copy");
        bus_write(1'b1, 8'h2B);
        expect_now("R4 second low no copy");

        // R9: field change while flag high
        bus_write(1'b0, 8'h42);
        bus_write(1'b1, 8'hAA);
        bus_write(1'b1, 8'hAB);
        expect_now("R9 flag held no copy");
        bus_write(1'b1, 8'h2B);
        exp_w[15:8] = 8'h42;
        expect_now("R9 falling write selects target");

        // R7: device clock pulse
        load(3'd5, 3'd1, 8'h01);
        expect_now("R7 ctrl_b set");
        check_bit("R7 dev_clk high", dev_clk, 1'b1);
        load(3'd5, 3'd1, 8'h00);
        expect_now("R7 ctrl_b cleared");
        check_bit("R7 dev_clk low", dev_clk, 1'b0);

        // R8: readback selection
        dev_out = 8'b0100_1000;
        wait_cyc(1);
        check_bit("R8 sel=6 bit", serial_out, 1'b1);
        load(3'd5, 3'd0, 8'h02);
        dev_out = 8'b1111_1011;
        wait_cyc(1);
        check_bit("R8 sel=2 bit", serial_out, 1'b0);
        load(3'd5, 3'd0, 8'h07);
        wait_cyc(1);
        check_bit("R8 sel=7 bit", serial_out, 1'b1);

        // R10: quiet bank with strobes idle
        wait_cyc(20);
        expect_now("R10 no spontaneous change");

        wait_cyc(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule